// File: doc/BRIEF.md
# UART register and command controller

This block is the software-facing register file of a byte-serial port. It sits on a simple register bus that decodes a 6-bit byte offset, so the address wraps every 64 bytes. It holds two mode bytes reached through a pointer that moves on its own, a transmit holding byte, a small receive queue, an interrupt mask and a sticky delta-break flag. It folds all of this into a status byte, an interrupt status byte and a single level interrupt line.

Software controls the port by writing command bytes. Each command byte carries three independent fields, and all three take effect from one write. The miscellaneous field acts first, then the transmitter field, then the receiver field.

Transmit bytes leave through a valid/ready handshake to a serializer. Received bytes and line-break events arrive from the deserializer side. Serialization, baud generation, parity and error detection live elsewhere, so status bits 7:4 always read zero.

Top module: `uart_regctl`

## Requirements
- R1: After synchronous reset, the status byte reads 0x08 (TxEMP only), and both mode bytes, the interrupt status and the mask read 0. `irq`, `tx_valid` and `rx_ready` are low.
- R2: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. The decoded read offsets are:
  - 0x00: mode byte selected by the pointer
  - 0x04: status
  - 0x0C: receive data
  - 0x14: interrupt status

  Every other offset reads 0, including 0x10, 0x18 and 0x1C. Writes to 0x04 and 0x10 change nothing.
- R3: A write to offset 0x00 stores into the mode byte selected by the pointer and then points the pointer at the second mode byte. A read of 0x00 returns the selected byte. Reset and miscellaneous command 1 point the pointer at the first mode byte.
- R4: A write to offset 0x08 is a command byte. Bits 1:0 control the receiver and bits 3:2 control the transmitter: 1 enables, 2 disables, and 0 or 3 leave the state alone.
- R5: Command bits 6:4 are a miscellaneous code, applied before the enable fields of the same byte:
  - 1 resets the mode pointer.
  - 2 disables the receiver and empties the queue.
  - 3 disables the transmitter and drops any pending byte, setting TxEMP.
  - 5 clears the delta-break flag.
  - 0, 4, 6 and 7, and bit 7 of the byte, have no effect.
- R6: Status bit 2 (TxRDY) equals the transmitter enable, and bit 3 is TxEMP.
  - A write to 0x0C stores the byte and clears TxEMP.
  - `tx_valid` is high while the transmitter is enabled and TxEMP is clear, with the byte on `tx_data`.
  - A cycle with `tx_valid` and `tx_ready` both high sets TxEMP.
- R7: The receive queue holds RXQ_DEPTH bytes in arrival order.
  - `rx_ready` is high while the receiver is enabled and the queue is not full.
  - A byte on `rx_valid` is stored only when `rx_ready` is high.
  - A read of 0x0C returns and removes the oldest byte, or returns 0 when the queue is empty.
  - Status bit 0 (RxRDY) means the queue is not empty, and bit 1 (FFULL) means it is full.
- R8: An `rx_break` cycle sets interrupt status bit 2 and stores a 0 byte, whether or not the receiver is enabled.
  - When the queue is full, the 0 byte overwrites the newest entry.
  - A break takes precedence over `rx_valid` in the same cycle.
- R9: Interrupt status bits:
  - Bit 0 equals TxRDY.
  - Bit 1 equals FFULL when bit 6 of the first mode byte is set, and RxRDY otherwise.
  - Bit 2 is the delta-break flag.
  - Bits 7 and 6:3 read 0.

  A write to 0x14 loads the mask. `irq` is high exactly when the interrupt status ANDed with the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte offered to serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue can take a byte |
| rx_break | input | 1 | Line break event |

## Verification
The bench targets the following corner cases, each of which a faulty design would expose:
- **Command bytes that combine a reset with an enable.** A design that applies the enable fields before the miscellaneous field would leave a port disabled that should be running.
- **A break arriving on a full queue, and a pop in the same cycle as a push.** A design that drops the break or overwrites the wrong entry would return data in the wrong order or leave the queue at the wrong fill level.
- **Toggling the receive-interrupt source bit while the queue is partly filled.** A design that always used the ready source, or that ignored the mask, would raise `irq` where it should not.
- **A transmit byte written while the transmitter is disabled.** A design that drops the byte or sends it early would show a mismatch on `tx_valid`.

// File: rtl/uart_regctl_pkg.sv
`timescale 1ns/1ps
package uart_regctl_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 6;

  // register offsets (address wraps at 64 bytes)
  localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_AUX   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQ   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_BAUD1 = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_BAUD2 = 6'h1C;

  // first mode byte: receive interrupt source select
  localparam int MODE_RXSRC_FULL = 6;

  typedef enum logic [2:0] {
    MISC_NOP       = 3'd0,
    MISC_PTR_RST   = 3'd1,
    MISC_RX_RST    = 3'd2,
    MISC_TX_RST    = 3'd3,
    MISC_ERR_RST   = 3'd4,
    MISC_DBRK_CLR  = 3'd5,
    MISC_BRK_START = 3'd6,
    MISC_BRK_STOP  = 3'd7
  } misc_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic dbrk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;
endpackage

// File: rtl/uart_cmd_decode.sv
`timescale 1ns/1ps
module uart_cmd_decode
  import uart_regctl_pkg::*;
(
  input  logic [6:0] cmd_bits,
  output cmd_act_t   act
);
  misc_e misc;

  always_comb begin
    misc = misc_e'(cmd_bits[6:4]);
    act  = '0;
    unique case (misc)
      MISC_PTR_RST:  act.ptr_rst  = 1'b1;
      MISC_RX_RST:   act.rx_rst   = 1'b1;
      MISC_TX_RST:   act.tx_rst   = 1'b1;
      MISC_DBRK_CLR: act.dbrk_clr = 1'b1;
      default:       ;
    endcase
    act.tx_on  = (cmd_bits[3:2] == 2'b01);
    act.tx_off = (cmd_bits[3:2] == 2'b10);
    act.rx_on  = (cmd_bits[1:0] == 2'b01);
    act.rx_off = (cmd_bits[1:0] == 2'b10);
  end
endmodule

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_we,
  input  logic         tx_rst,
  input  logic         tx_on,
  input  logic         tx_off,
  input  logic         buf_we,
  input  logic [W-1:0] buf_data,
  input  logic         out_ready,
  output logic         enabled,
  output logic         empty,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  assign out_valid = enabled && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled  <= 1'b0;
      empty    <= 1'b1;
      out_data <= '0;
    end else begin
      // enable field wins over the misc reset of the same command (R5)
      if (cmd_we) begin
        if (tx_on)       enabled <= 1'b1;
        else if (tx_off) enabled <= 1'b0;
        else if (tx_rst) enabled <= 1'b0;
      end
      if (buf_we) begin
        out_data <= buf_data;
        empty    <= 1'b0;
      end else if (cmd_we && tx_rst) begin
        empty <= 1'b1;
      end else if (out_valid && out_ready) begin
        empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue #(
  parameter int DEPTH = 4,   // power of two, at least 2
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         pop,
  input  logic         push,        // only when not full
  input  logic         push_force,  // overwrites newest entry when full
  input  logic [W-1:0] push_data,
  output logic [W-1:0] head_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  logic          wr_req, pop_do, stay_full, grow;
  logic [AW-1:0] wr_idx;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign head_data = mem[rd_ptr];

  assign wr_req    = push || push_force;
  assign pop_do    = pop && !empty;
  assign stay_full = full && !pop_do;
  assign wr_idx    = stay_full ? (wr_ptr - AW'(1)) : wr_ptr;
  assign grow      = wr_req && !stay_full;

  always_ff @(posedge clk) begin
    if (wr_req && !flush)
      mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_do) rd_ptr <= rd_ptr + AW'(1);
      if (grow)   wr_ptr <= wr_ptr + AW'(1);
      count <= count + CW'(grow) - CW'(pop_do);
    end
  end
endmodule

// File: rtl/uart_regctl.sv
`timescale 1ns/1ps
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int RXQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [REG_W-1:0]  tx_data,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_data,
  output logic              rx_ready,
  input  logic              rx_break
);
  localparam int NMODE = 2;

  logic [REG_W-1:0] mode_q [NMODE];
  logic             mode_sel;
  logic [REG_W-1:0] imr_q;
  logic             rx_en_q;
  logic             dbrk_q;

  logic wr_mode, wr_cmd, wr_txb, wr_imr, rd_data;
  cmd_act_t act;

  logic             tx_en, tx_emp;
  logic [REG_W-1:0] q_head, q_push_data;
  logic             q_empty, q_full, q_push;
  logic [REG_W-1:0] status, isr, rd_mux;

  assign wr_mode = reg_wr && (reg_addr == OFS_MODE);
  assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
  assign wr_txb  = reg_wr && (reg_addr == OFS_DATA);
  assign wr_imr  = reg_wr && (reg_addr == OFS_IRQ);
  assign rd_data = reg_rd && (reg_addr == OFS_DATA);

  uart_cmd_decode u_dec (
    .cmd_bits (reg_wdata[6:0]),
    .act      (act)
  );

  uart_tx_hold #(.W(REG_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (wr_cmd),
    .tx_rst    (act.tx_rst),
    .tx_on     (act.tx_on),
    .tx_off    (act.tx_off),
    .buf_we    (wr_txb),
    .buf_data  (reg_wdata),
    .out_ready (tx_ready),
    .enabled   (tx_en),
    .empty     (tx_emp),
    .out_valid (tx_valid),
    .out_data  (tx_data)
  );

  // break beats data in the same cycle (R8)
  assign rx_ready    = rx_en_q && !q_full;
  assign q_push      = rx_valid && rx_ready && !rx_break;
  assign q_push_data = rx_break ? '0 : rx_data;

  uart_rx_queue #(.DEPTH(RXQ_DEPTH), .W(REG_W)) u_rxq (
    .clk        (clk),
    .rst        (rst),
    .flush      (wr_cmd && act.rx_rst),
    .pop        (rd_data),
    .push       (q_push),
    .push_force (rx_break),
    .push_data  (q_push_data),
    .head_data  (q_head),
    .empty      (q_empty),
    .full       (q_full)
  );

  // status and interrupt status (R6, R7, R9)
  assign status = {4'b0000, tx_emp, tx_en, q_full, !q_empty};
  assign isr    = {5'b00000, dbrk_q,
                   (mode_q[0][MODE_RXSRC_FULL] ? q_full : !q_empty),
                   tx_en};
  assign irq    = |(isr & imr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NMODE; i++) mode_q[i] <= '0;
      mode_sel <= 1'b0;
      imr_q    <= '0;
      rx_en_q  <= 1'b0;
      dbrk_q   <= 1'b0;
    end else begin
      if (wr_mode) begin                       // R3
        mode_q[mode_sel] <= reg_wdata;
        mode_sel         <= 1'b1;
      end else if (wr_cmd && act.ptr_rst) begin
        mode_sel <= 1'b0;
      end
      if (wr_imr) imr_q <= reg_wdata;
      if (wr_cmd) begin                        // R4, R5
        if (act.rx_on)       rx_en_q <= 1'b1;
        else if (act.rx_off) rx_en_q <= 1'b0;
        else if (act.rx_rst) rx_en_q <= 1'b0;
      end
      if (rx_break)                    dbrk_q <= 1'b1;
      else if (wr_cmd && act.dbrk_clr) dbrk_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MODE: rd_mux = mode_q[mode_sel];
      OFS_STAT: rd_mux = status;
      OFS_DATA: rd_mux = q_empty ? '0 : q_head;
      OFS_IRQ:  rd_mux = isr;
      default:  rd_mux = '0;                   // R2
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/uart_regctl_chk.sv
`timescale 1ns/1ps
module uart_regctl_chk
  import uart_regctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [REG_W-1:0]  tx_data,
  input logic              rx_ready
);
  logic wr_cmd;
  assign wr_cmd = reg_wr && (reg_addr == OFS_CMD);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready && !reg_wr |=> tx_valid && $stable(tx_data)); // R6

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && !reg_wr |=> !tx_valid); // R6

  AST_TX_OFF: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && reg_wdata[3:2] == 2'b10 |=> !tx_valid); // R4

  AST_RX_OFF: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && reg_wdata[1:0] == 2'b10 |=> !rx_ready); // R4

  AST_RX_RESET: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && reg_wdata[6:4] == 3'd2 && reg_wdata[1:0] != 2'b01 |=> !rx_ready); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == OFS_IRQ && reg_wdata == '0 |=> !irq); // R9

  AST_BAUD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd && (reg_addr == OFS_BAUD1 || reg_addr == OFS_BAUD2) |=> reg_rdata == '0); // R2
endmodule

bind uart_regctl uart_regctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .rx_ready  (rx_ready)
);

// File: tb/tb_uart_regctl.sv
`timescale 1ns/1ps
module tb_uart_regctl;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, tx_valid, tx_ready, rx_valid, rx_ready, rx_break;
  logic [7:0] tx_data, rx_data;

  always #10 clk = ~clk;

  uart_regctl #(.RXQ_DEPTH(D)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_break(rx_break)
  );

  int checks = 0;
  int fails  = 0;
  string tag_ovr = "";

  // reference model state
  logic [7:0] m_mode [2];
  int         m_sel;
  logic [7:0] m_imr, m_txb;
  bit         m_txen, m_txemp, m_rxen, m_db;
  logic [7:0] m_q [D];
  int         m_cnt;

  task automatic model_reset();
    m_mode[0] = 0; m_mode[1] = 0; m_sel = 0; m_imr = 0; m_txb = 0;
    m_txen = 0; m_txemp = 1; m_rxen = 0; m_db = 0; m_cnt = 0;
  endtask

  function automatic logic [7:0] exp_sr();
    return {4'b0, m_txemp, m_txen, (m_cnt == D), (m_cnt != 0)};
  endfunction

  function automatic logic [7:0] exp_isr();
    logic rxs;
    rxs = m_mode[0][6] ? (m_cnt == D) : (m_cnt != 0);
    return {5'b0, m_db, rxs, m_txen};
  endfunction

  function automatic logic [7:0] exp_read(logic [5:0] a);
    case (a)
      6'h00:   return m_mode[m_sel];
      6'h04:   return exp_sr();
      6'h0C:   return (m_cnt > 0) ? m_q[0] : 8'h00;
      6'h14:   return exp_isr();
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (a)
      6'h00:   return "R3";
      6'h04:   return "R6";
      6'h0C:   return "R7";
      6'h14:   return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_update(bit wr, bit rd, logic [5:0] a, logic [7:0] d,
                              bit rxv, logic [7:0] rxd, bit brk, bit txr);
    bit pre_rdy, pre_hs, cmd;
    logic [2:0] misc;
    pre_rdy = m_rxen && (m_cnt < D);
    pre_hs  = m_txen && !m_txemp && txr;
    cmd     = wr && (a == 6'h08);
    misc    = d[6:4];
    // transmitter
    if (wr && a == 6'h0C) begin m_txb = d; m_txemp = 0; end
    else if (cmd && misc == 3) m_txemp = 1;
    else if (pre_hs) m_txemp = 1;
    if (cmd) begin
      if (d[3:2] == 2'b01) m_txen = 1;
      else if (d[3:2] == 2'b10) m_txen = 0;
      else if (misc == 3) m_txen = 0;
      if (d[1:0] == 2'b01) m_rxen = 1;
      else if (d[1:0] == 2'b10) m_rxen = 0;
      else if (misc == 2) m_rxen = 0;
    end
    // mode pointer
    if (wr && a == 6'h00) begin m_mode[m_sel] = d; m_sel = 1; end
    else if (cmd && misc == 1) m_sel = 0;
    if (wr && a == 6'h14) m_imr = d;
    if (brk) m_db = 1;
    else if (cmd && misc == 5) m_db = 0;
    // queue
    if (cmd && misc == 2) m_cnt = 0;
    else begin
      if (rd && a == 6'h0C && m_cnt > 0) begin
        for (int i = 0; i < D - 1; i++) m_q[i] = m_q[i+1];
        m_cnt--;
      end
      if (brk) begin
        if (m_cnt == D) m_q[D-1] = 8'h00;
        else begin m_q[m_cnt] = 8'h00; m_cnt++; end
      end else if (rxv && pre_rdy) begin
        m_q[m_cnt] = rxd; m_cnt++;
      end
    end
  endtask

  // one bus cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit wr, bit rd, logic [5:0] a, logic [7:0] d,
                      bit rxv, logic [7:0] rxd, bit brk, bit txr);
    logic [7:0] rexp;
    string rtag;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    rx_valid = rxv; rx_data = rxd; rx_break = brk; tx_ready = txr;
    rexp = exp_read(a);
    rtag = (tag_ovr != "") ? tag_ovr : tag_of(a);
    @(posedge clk);
    model_update(wr, rd, a, d, rxv, rxd, brk, txr);
    @(negedge clk);
    chk("R9", "irq", {7'b0, irq}, {7'b0, |(exp_isr() & m_imr)});
    chk("R7", "rx_ready", {7'b0, rx_ready}, {7'b0, m_rxen && (m_cnt < D)});
    chk("R6", "tx_valid", {7'b0, tx_valid}, {7'b0, m_txen && !m_txemp});
    if (m_txen && !m_txemp) chk("R6", "tx_data", tx_data, m_txb);
    if (rd) chk(rtag, $sformatf("read %h", a), reg_rdata, rexp);
  endtask

  task automatic wr_reg(logic [5:0] a, logic [7:0] d);
    step(1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(logic [5:0] a);
    step(0, 1, a, 0, 0, 0, 0, 0);
  endtask
  task automatic idle(bit txr);
    step(0, 0, 0, 0, 0, 0, 0, txr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_break = 0; tx_ready = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1", "irq", {7'b0, irq}, 8'h00);
    chk("R1", "tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1", "rx_ready", {7'b0, rx_ready}, 8'h00);
    tag_ovr = "R1";
    rd_reg(6'h04); rd_reg(6'h00); rd_reg(6'h14);

    // R3 mode pointer sequencing
    tag_ovr = "R3";
    wr_reg(6'h00, 8'h40);
    rd_reg(6'h00);
    wr_reg(6'h00, 8'h5A);
    wr_reg(6'h00, 8'h33);
    rd_reg(6'h00);
    wr_reg(6'h08, 8'h10);
    rd_reg(6'h00);
    wr_reg(6'h00, 8'h00);

    // R4 enable / disable / reserved codes
    tag_ovr = "R4";
    wr_reg(6'h08, 8'h05);
    rd_reg(6'h04);
    wr_reg(6'h14, 8'h01);
    wr_reg(6'h08, 8'h08);
    rd_reg(6'h04);
    wr_reg(6'h08, 8'h0F);
    rd_reg(6'h04);
    wr_reg(6'h08, 8'h04);
    chk("R4", "irq after tx on", {7'b0, irq}, 8'h01);

    // R6 transmit handshake
    tag_ovr = "R6";
    wr_reg(6'h0C, 8'hA5);
    idle(0); idle(0);
    rd_reg(6'h04);
    idle(1);
    rd_reg(6'h04);
    wr_reg(6'h08, 8'h08);
    wr_reg(6'h0C, 8'h3C);
    idle(1);
    wr_reg(6'h08, 8'h04);
    chk("R6", "pending byte after re-enable", tx_data, 8'h3C);
    idle(1);
    // R5 transmitter reset combined with enable
    tag_ovr = "R5";
    wr_reg(6'h0C, 8'h77);
    wr_reg(6'h08, 8'h34);
    chk("R5", "tx_valid after tx reset+on", {7'b0, tx_valid}, 8'h00);
    rd_reg(6'h04);

    // R7 receive queue fill, overflow and drain
    tag_ovr = "R7";
    wr_reg(6'h08, 8'h01);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 8'h10 + 8'(i), 0, 0);
    chk("R7", "rx_ready when full", {7'b0, rx_ready}, 8'h00);
    rd_reg(6'h04);
    for (int i = 0; i < 5; i++) rd_reg(6'h0C);

    // R8 break handling
    tag_ovr = "R8";
    wr_reg(6'h08, 8'h02);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    rd_reg(6'h14);
    rd_reg(6'h0C);
    wr_reg(6'h08, 8'h01);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'hC1 + 8'(i), 0, 0);
    step(0, 0, 0, 0, 1, 8'hEE, 1, 0);
    rd_reg(6'h04);
    for (int i = 0; i < 4; i++) rd_reg(6'h0C);
    rd_reg(6'h14);
    wr_reg(6'h08, 8'h50);
    rd_reg(6'h14);

    // R5 receiver reset, no-op codes, bit 7
    tag_ovr = "R5";
    step(0, 0, 0, 0, 1, 8'h99, 0, 0);
    wr_reg(6'h08, 8'h40);
    wr_reg(6'h08, 8'h60);
    wr_reg(6'h08, 8'hF0);
    wr_reg(6'h08, 8'h80);
    rd_reg(6'h04);
    wr_reg(6'h08, 8'h21);
    rd_reg(6'h04);
    chk("R5", "rx_ready after reset+on", {7'b0, rx_ready}, 8'h01);

    // R2 ignored writes and zero reads
    tag_ovr = "R2";
    wr_reg(6'h04, 8'hFF);
    wr_reg(6'h10, 8'hFF);
    rd_reg(6'h04);
    rd_reg(6'h10); rd_reg(6'h18); rd_reg(6'h1C); rd_reg(6'h01); rd_reg(6'h3C);

    // R9 receive interrupt source select
    tag_ovr = "R9";
    wr_reg(6'h14, 8'h02);
    step(0, 0, 0, 0, 1, 8'h42, 0, 0);
    rd_reg(6'h14);
    wr_reg(6'h08, 8'h10);
    wr_reg(6'h00, 8'h40);
    rd_reg(6'h14);
    chk("R9", "irq with full-source and one byte", {7'b0, irq}, 8'h00);
    wr_reg(6'h08, 8'h10);
    wr_reg(6'h00, 8'h00);
    rd_reg(6'h14);
    wr_reg(6'h14, 8'h00);

    // random phase
    tag_ovr = "";
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      int op;
      int sel;
      logic [5:0] a;
      logic [7:0] d;
      bit brk;
      op  = $urandom_range(0, 9);
      sel = $urandom_range(0, 8);
      case (sel)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C;
        4: a = 6'h10; 5: a = 6'h14; 6: a = 6'h18; 7: a = 6'h1C;
        default: a = 6'($urandom);
      endcase
      d = 8'($urandom);
      // keep receiver resets rare
      if (a == 6'h08 && d[6:4] == 3'd2 && $urandom_range(0, 3) != 0) d[6:4] = 3'd0;
      brk = ($urandom_range(0, 40) == 0);
      if (op < 3)
        step(1, 0, a, d, $urandom_range(0, 1) == 1, 8'($urandom), brk, $urandom_range(0, 1) == 1);
      else if (op < 6)
        step(0, 1, a, 0, $urandom_range(0, 1) == 1, 8'($urandom), brk, $urandom_range(0, 1) == 1);
      else
        step(0, 0, 0, 0, $urandom_range(0, 1) == 1, 8'($urandom), brk, $urandom_range(0, 1) == 1);
    end
    idle(0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule